// File: doc/BRIEF.md
# Two-Wire Slave Address Match and Interrupt Request Logic

This block sits behind the bit-level shifter of a slave-only two-wire control port. When the shifter has assembled the first byte of a transfer, it presents that byte here. The block then reports whether the byte addresses this particular unit or the broadcast address that every unit shares. The unit address is formed from a fixed three-bit prefix and four pin-strapped bits. That lets sixteen units share one bus. The broadcast address lets the host push the same write to all of them at once.

The block also collects per-port event pulses into a sticky event register. A mask register lets any event be ignored, and a clear register lets software drop events it has handled. When any enabled event is pending, the block requests an interrupt on an active-low, open-drain pin. The pin is held steady while a bus transaction is in progress, so a host never sees the request change in the middle of a read. Anything that arrived during the transfer shows up on the pin right after the stop condition.

Top module: `twi_addr_irq`

## Requirements
- R1: When `addrValid` is high and `addrByte[7:1]` equals binary 010 followed by `straps[3:0]`, `unitMatch` is high after the next clock edge, for either value of the direction bit `addrByte[0]` (1 = read).
- R2: When `addrValid` is high and `addrByte[7:1]` equals 7'h30, `bcastMatch` is high after the next edge only if `addrByte[0]` is 0 (write); a read to that address leaves both match outputs low.
- R3: Any other address leaves both match outputs low. `txStop` clears both match outputs at the next edge.
- R4: A high bit of `evtPulse` sets the matching event bit, and that bit stays set until it is cleared, whatever the mask says.
- R5: A write to offset 8'h01 loads the mask, where a 1 enables an event. A pending event whose mask bit is 0 does not pull `intN` low, and enabling that bit later does pull `intN` low.
- R6: A write to offset 8'h1A clears every event bit whose data bit is 1. An event pulse in the same cycle as the clear keeps its bit set.
- R7: Outside a transaction, `intN` is low exactly when some enabled event bit is set. It follows the event register one clock later, so an event pulse reaches the pin two edges after it is sampled.
- R8: From the edge that samples `txStart` until the edge that samples `txStop`, `intN` holds its value. It takes the current pending state one edge after the stop.
- R9: The active-low synchronous reset `rstN` sets `intN` high, both match outputs low, all event bits clear and all mask bits enabled.
- R10: Register writes to any offset other than 8'h01 and 8'h1A change neither the mask nor the event register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous reset, active low |
| straps | input | 4 | Pin-strapped low address bits |
| addrByte | input | 8 | Received address byte; [7:1] address, [0] direction (1 = read) |
| addrValid | input | 1 | One-cycle strobe: `addrByte` is valid |
| txStart | input | 1 | One-cycle strobe: start condition seen |
| txStop | input | 1 | One-cycle strobe: stop condition seen |
| regWrEn | input | 1 | One-cycle register write strobe |
| regAddr | input | 8 | Register offset of the write |
| regWrData | input | 8 | Register write data |
| evtPulse | input | 8 | Per-event pulses, one bit per event source |
| unitMatch | output | 1 | Last address byte addressed this unit |
| bcastMatch | output | 1 | Last address byte was a broadcast write |
| intN | output | 1 | Interrupt request, active low; drives low or releases |

## Verification
The match outputs are due one edge after `addrValid` and hold until the stop. Mask, clear and event changes reach the register one edge after their strobe, and `intN` one edge after that. The pin follows the stop edge by one more edge. Every expectation in the bench is queued for the edge on which the result is due, and is compared shortly after that edge. Where it matters, the bench also queues the unchanged value for the edge before. That catches a pin that moves too early as well as one that moves too late. Freeze checks compare `intN` on several edges inside an open transaction, and once more on the edge after the stop.

// File: rtl/twi_irq_pkg.sv
package twi_irq_pkg;
  // Strobes from the control half to the datapath half
  typedef struct packed {
    logic maskWr;  // load mask register this cycle
    logic clrWr;   // clear selected event bits this cycle
    logic hold;    // transaction open: freeze the pin
  } irqCtl_t;
endpackage

// File: rtl/twi_irq_ctrl.sv
module twi_irq_ctrl
  import twi_irq_pkg::*;
#(
  parameter int          STRAP_W     = 4,
  parameter int          ADDR_W      = 7,
  parameter int          OFF_W       = 8,
  parameter logic [ADDR_W-STRAP_W-1:0] UNIT_PREFIX = 3'b010,
  parameter logic [ADDR_W-1:0] BCAST_ADDR = 7'h30,
  parameter logic [OFF_W-1:0]  MASK_OFF   = 8'h01,
  parameter logic [OFF_W-1:0]  CLR_OFF    = 8'h1A
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] straps,
  input  logic [ADDR_W:0]    addrByte,
  input  logic               addrValid,
  input  logic               txStart,
  input  logic               txStop,
  input  logic               regWrEn,
  input  logic [OFF_W-1:0]   regAddr,
  output logic               unitMatch,
  output logic               bcastMatch,
  output irqCtl_t            ctl
);
  localparam int PREFIX_W = ADDR_W - STRAP_W;

  logic [ADDR_W-1:0] rxAddr;
  logic              rxRead;
  logic [ADDR_W-1:0] unitAddr;
  logic              hitUnit;
  logic              hitBcast;
  logic              busyQ;
  logic              unitQ;
  logic              bcastQ;

  assign rxAddr   = addrByte[ADDR_W:1];
  assign rxRead   = addrByte[0];
  assign unitAddr = {UNIT_PREFIX, straps};
  assign hitUnit  = (rxAddr == unitAddr);
  // Broadcast accepts writes only
  assign hitBcast = (rxAddr == BCAST_ADDR) && !rxRead;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ  <= 1'b0;
      unitQ  <= 1'b0;
      bcastQ <= 1'b0;
    end else begin
      if (txStop)       busyQ <= 1'b0;
      else if (txStart) busyQ <= 1'b1;

      if (txStop) begin
        unitQ  <= 1'b0;
        bcastQ <= 1'b0;
      end else if (addrValid) begin
        unitQ  <= hitUnit;
        bcastQ <= hitBcast;
      end else if (txStart) begin
        unitQ  <= 1'b0;
        bcastQ <= 1'b0;
      end
    end
  end

  assign unitMatch  = unitQ;
  assign bcastMatch = bcastQ;

  always_comb begin
    ctl        = '0;
    ctl.maskWr = regWrEn && (regAddr == MASK_OFF);
    ctl.clrWr  = regWrEn && (regAddr == CLR_OFF);
    ctl.hold   = busyQ;
  end

  logic unusedPrefixW;
  assign unusedPrefixW = (PREFIX_W > 0);
endmodule

// File: rtl/twi_irq_dp.sv
module twi_irq_dp
  import twi_irq_pkg::*;
#(
  parameter int EVT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  irqCtl_t          ctl,
  input  logic [EVT_W-1:0] wrData,
  input  logic [EVT_W-1:0] evtPulse,
  output logic             intN
);
  logic [EVT_W-1:0] evtQ;
  logic [EVT_W-1:0] maskQ;
  logic             intNQ;

  // One sticky cell per event source; a new pulse beats a clear
  for (genvar i = 0; i < EVT_W; i++) begin : g_evt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        evtQ[i]  <= 1'b0;
        maskQ[i] <= 1'b1;
      end else begin
        if (evtPulse[i])                  evtQ[i] <= 1'b1;
        else if (ctl.clrWr && wrData[i])  evtQ[i] <= 1'b0;
        if (ctl.maskWr)                   maskQ[i] <= wrData[i];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         intNQ <= 1'b1;
    else if (!ctl.hold) intNQ <= ~|(evtQ & maskQ);
  end

  assign intN = intNQ;
endmodule

// File: rtl/twi_addr_irq.sv
module twi_addr_irq
  import twi_irq_pkg::*;
#(
  parameter int STRAP_W = 4,
  parameter int EVT_W   = 8,
  parameter int OFF_W   = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [STRAP_W-1:0] straps,
  input  logic [7:0]         addrByte,
  input  logic               addrValid,
  input  logic               txStart,
  input  logic               txStop,
  input  logic               regWrEn,
  input  logic [OFF_W-1:0]   regAddr,
  input  logic [EVT_W-1:0]   regWrData,
  input  logic [EVT_W-1:0]   evtPulse,
  output logic               unitMatch,
  output logic               bcastMatch,
  output logic               intN
);
  irqCtl_t ctl;

  twi_irq_ctrl #(
    .STRAP_W(STRAP_W), .ADDR_W(7), .OFF_W(OFF_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .straps(straps), .addrByte(addrByte),
    .addrValid(addrValid), .txStart(txStart), .txStop(txStop),
    .regWrEn(regWrEn), .regAddr(regAddr),
    .unitMatch(unitMatch), .bcastMatch(bcastMatch), .ctl(ctl)
  );

  twi_irq_dp #(.EVT_W(EVT_W)) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl), .wrData(regWrData),
    .evtPulse(evtPulse), .intN(intN)
  );
endmodule

// File: rtl/twi_addr_irq_chk.sv
module twi_addr_irq_chk #(
  parameter int STRAP_W = 4
) (
  input logic               clk,
  input logic               rstN,
  input logic [STRAP_W-1:0] straps,
  input logic [7:0]         addrByte,
  input logic               addrValid,
  input logic               txStart,
  input logic               txStop,
  input logic               unitMatch,
  input logic               bcastMatch,
  input logic               intN
);
  // Independent record of whether a transaction is open
  logic inTx;
  always_ff @(posedge clk) begin
    if (!rstN)        inTx <= 1'b0;
    else if (txStop)  inTx <= 1'b0;
    else if (txStart) inTx <= 1'b1;
  end

  p_unit_src_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(unitMatch) |-> $past(addrValid && addrByte[7:1] == {3'b010, straps}));

  p_bcast_src_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(bcastMatch) |-> $past(addrValid && addrByte == 8'h60));

  p_one_match_r3: assert property (@(posedge clk) disable iff (!rstN)
    !(unitMatch && bcastMatch));

  p_stop_clears_r3: assert property (@(posedge clk) disable iff (!rstN)
    txStop |=> (!unitMatch && !bcastMatch));

  p_pin_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    inTx |=> $stable(intN));
endmodule

bind twi_addr_irq twi_addr_irq_chk #(.STRAP_W(STRAP_W)) chk_i (
  .clk(clk), .rstN(rstN), .straps(straps), .addrByte(addrByte),
  .addrValid(addrValid), .txStart(txStart), .txStop(txStop),
  .unitMatch(unitMatch), .bcastMatch(bcastMatch), .intN(intN)
);

// File: tb/twi_addr_irq_tb.sv
module twi_addr_irq_tb_top;
  logic       clk = 1'b0;
  logic       rstN;
  logic [3:0] straps;
  logic [7:0] addrByte;
  logic       addrValid, txStart, txStop, regWrEn;
  logic [7:0] regAddr, regWrData, evtPulse;
  logic       unitMatch, bcastMatch, intN;

  always #4 clk = ~clk;  // 125 MHz

  twi_addr_irq dut_i (
    .clk(clk), .rstN(rstN), .straps(straps), .addrByte(addrByte),
    .addrValid(addrValid), .txStart(txStart), .txStop(txStop),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData),
    .evtPulse(evtPulse), .unitMatch(unitMatch), .bcastMatch(bcastMatch),
    .intN(intN)
  );

  typedef struct {
    logic  expInt;
    logic  expUnit;
    logic  expBcast;
    string tag;
  } expItem_t;

  expItem_t expQ[$];
  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  // Expectation for the state just after the next rising edge
  task automatic expect_next(input logic i, input logic u, input logic b, input string tag);
    expItem_t e;
    e.expInt = i; e.expUnit = u; e.expBcast = b; e.tag = tag;
    expQ.push_back(e);
  endtask

  // Monitor: compares shortly after each edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      while (expQ.size() > 0) begin
        expItem_t e;
        e = expQ.pop_front();
        checks++;
        if (intN !== e.expInt || unitMatch !== e.expUnit || bcastMatch !== e.expBcast) begin
          errors++;
          $display("FAIL %s: got intN=%b unit=%b bcast=%b, expected intN=%b unit=%b bcast=%b",
                   e.tag, intN, unitMatch, bcastMatch, e.expInt, e.expUnit, e.expBcast);
        end
      end
    end
  end

  task automatic idle();
    addrValid = 0; txStart = 0; txStop = 0; regWrEn = 0; evtPulse = '0;
  endtask

  task automatic pulse_start();
    @(negedge clk); txStart = 1; @(negedge clk); txStart = 0;
  endtask

  task automatic pulse_stop();
    @(negedge clk); txStop = 1; @(negedge clk); txStop = 0;
  endtask

  task automatic send_addr(input logic [7:0] b);
    @(negedge clk); addrByte = b; addrValid = 1; @(negedge clk); addrValid = 0;
  endtask

  task automatic reg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk); regAddr = off; regWrData = d; regWrEn = 1;
    @(negedge clk); regWrEn = 0;
  endtask

  task automatic fire_evt(input logic [7:0] bits);
    @(negedge clk); evtPulse = bits; @(negedge clk); evtPulse = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got no finish, expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle();
    straps = 4'b1010; addrByte = '0; regAddr = '0; regWrData = '0;
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    expect_next(1, 0, 0, "R9 reset state");
    @(negedge clk);

    // R1 unit write and read
    pulse_start();
    send_addr({3'b010, 4'b1010, 1'b0});
    expect_next(1, 1, 0, "R1 unit write match");
    pulse_stop();
    expect_next(1, 0, 0, "R3 stop clears match");
    pulse_start();
    send_addr({3'b010, 4'b1010, 1'b1});
    expect_next(1, 1, 0, "R1 unit read match");
    pulse_stop();

    // R2 broadcast write accepted, read refused
    pulse_start();
    send_addr(8'h60);
    expect_next(1, 0, 1, "R2 broadcast write");
    pulse_stop();
    pulse_start();
    send_addr(8'h61);
    expect_next(1, 0, 0, "R2 broadcast read refused");
    pulse_stop();

    // R3 foreign addresses
    pulse_start();
    send_addr({3'b010, 4'b1011, 1'b0});
    expect_next(1, 0, 0, "R3 other strap value");
    send_addr({3'b110, 4'b1010, 1'b0});
    expect_next(1, 0, 0, "R3 other prefix");
    pulse_stop();

    // R9 mask enabled after reset, R7 latency
    @(negedge clk); evtPulse = 8'h80;
    expect_next(1, 0, 0, "R7 pin not yet moved");
    @(negedge clk); evtPulse = '0;
    expect_next(0, 0, 0, "R9 R7 event bit7 asserts pin");
    @(negedge clk);
    reg_write(8'h1A, 8'h80);
    expect_next(1, 0, 0, "R6 clear releases pin");
    @(negedge clk);

    // R5 masking, R4 event stays latched while masked
    reg_write(8'h01, 8'hFE);
    fire_evt(8'h01);
    expect_next(1, 0, 0, "R5 masked event ignored");
    @(negedge clk);
    expect_next(1, 0, 0, "R5 masked event still ignored");
    reg_write(8'h01, 8'hFF);
    expect_next(0, 0, 0, "R4 R5 latched event shows once enabled");
    reg_write(8'h1A, 8'h01);
    expect_next(1, 0, 0, "R6 clear bit0");
    @(negedge clk);

    // R6 event beats clear in the same cycle
    @(negedge clk); evtPulse = 8'h04; regAddr = 8'h1A; regWrData = 8'h04; regWrEn = 1;
    @(negedge clk); evtPulse = '0; regWrEn = 0;
    expect_next(0, 0, 0, "R6 simultaneous event kept");
    reg_write(8'h1A, 8'h04);
    expect_next(1, 0, 0, "R6 later clear releases");
    @(negedge clk);

    // R10 writes to other offsets ignored
    fire_evt(8'h08);
    expect_next(0, 0, 0, "R4 event bit3 asserts");
    reg_write(8'h05, 8'h00);
    expect_next(0, 0, 0, "R10 offset 05 touches no mask");
    reg_write(8'h1B, 8'hFF);
    expect_next(0, 0, 0, "R10 offset 1B clears nothing");
    reg_write(8'h1A, 8'h08);
    expect_next(1, 0, 0, "R6 clear bit3");
    @(negedge clk);

    // R8 freeze during transaction
    pulse_start();
    fire_evt(8'h02);
    expect_next(1, 0, 0, "R8 pin frozen high");
    @(negedge clk);
    expect_next(1, 0, 0, "R8 pin still frozen high");
    @(negedge clk);
    @(negedge clk); txStop = 1;
    expect_next(1, 0, 0, "R8 frozen at stop edge");
    @(negedge clk); txStop = 0;
    expect_next(0, 0, 0, "R8 pin updates after stop");
    @(negedge clk);
    pulse_start();
    reg_write(8'h1A, 8'h02);
    expect_next(0, 0, 0, "R8 pin frozen low");
    @(negedge clk);
    pulse_stop();
    expect_next(1, 0, 0, "R8 release shown after stop");
    @(negedge clk);
    @(negedge clk);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule